// File: doc/BRIEF.md
# Planar Read Path with Colour Compare

This block is the host-read side of a graphics memory organised as four 8-bit planes that share one address. For every byte the host reads, it fetches the four plane bytes at that address in one access and loads them into a 32-bit latch. The latch is also brought out as a port, so a neighbouring write datapath can use it. The byte returned to the host depends on the read mode. In plane-select mode the block returns the byte of one plane. In compare mode it returns eight per-pixel match flags, one for each bit position across the four planes. Planes that are marked as don't-care take no part in the compare.

The host issues one request per valid/ready handshake. A request of two or four bytes is broken into single-byte plane reads at ascending addresses, and the results are packed little-endian. The plane memory sits outside the block, behind a port that returns data with a variable latency. The block has one memory read outstanding at a time. The mode and compare settings are sampled when a request is accepted and stay fixed for that request.

Top module: `plane_read_path`

## Requirements
- R1: While reset is held and in the cycle after it is released, req_ready is 1, and rsp_valid, mem_rd_en and latch_q are 0.
- R2: Every returned plane access loads latch_q with the 32-bit memory word in either read mode. Plane p sits in bits 8p+7..8p. After a response, latch_q holds the planes of the last byte address of that request.
- R3: When rd_mode is 0, each result byte is the byte of the plane numbered by map_sel (0..3).
- R4: When rd_mode is 1, result bit i is 1 exactly when, for every plane p whose bit p of dont_care is 1, plane p's bit i equals bit p of cmp_colour.
- R5: A plane whose dont_care bit is 0 is left out of the compare. With dont_care equal to 0, every result byte is 8'hFF.
- R6: req_size 0 reads 1 byte, 1 reads 2 bytes, and 2 or 3 reads 4 bytes. The block reads addresses req_addr, req_addr+1, and so on, wrapping modulo 2^ADDR_W. Byte k of the request goes to rsp_data bits 8k+7..8k, and unused upper bytes are 0.
- R7: req_ready is 1 only while the block is idle. Only one memory read is outstanding at a time. rsp_valid is a one-cycle pulse that rises one cycle after the cycle in which the last plane data is returned.
- R8: rd_mode, map_sel, cmp_colour and dont_care are sampled when a request is accepted. Changing them while the request is in progress has no effect on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host read request |
| req_ready | output | 1 | Block idle, request accepted when both are high |
| req_addr | input | ADDR_W | First byte address |
| req_size | input | 2 | 0: one byte, 1: two bytes, 2/3: four bytes |
| rd_mode | input | 1 | 0: plane select, 1: colour compare |
| map_sel | input | 2 | Plane returned in plane-select mode |
| cmp_colour | input | 4 | Compare colour, one bit per plane |
| dont_care | input | 4 | 1 = plane takes part in compare |
| mem_rd_en | output | 1 | Plane memory read strobe |
| mem_rd_addr | output | ADDR_W | Plane memory read address |
| mem_rd_valid | input | 1 | Plane memory data returned |
| mem_rd_data | input | 32 | Four plane bytes, plane p in bits 8p+7..8p |
| rsp_valid | output | 1 | Result valid pulse |
| rsp_data | output | 32 | Result bytes, little-endian |
| latch_q | output | 32 | Plane latch for the write path |

## Verification
The hardest case to reach from the ports is a compare where some planes disagree with the compare colour but are masked as don't-care. The result must then show a match only because those planes are excluded. The bench drives directed patterns with partial don't-care masks over plane contents that vary with the address, and adds many random masks and colours. It also changes the settings during a four-byte read that wraps past the top address, which checks both the sampling at acceptance and the address wrap within one request.

// File: rtl/plr_pkg.sv
package plr_pkg;
  localparam int NPLANE  = 4;
  localparam int PLANE_W = 8;
  localparam int WORD_W  = NPLANE * PLANE_W;
  localparam int NLANE   = 4;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} plr_state_e;

  typedef struct packed {
    logic                 mode;
    logic [1:0]           map;
    logic [NPLANE-1:0]    cmp;
    logic [NPLANE-1:0]    dc;
  } plr_cfg_t;

  // Index of the last byte for a size code.
  function automatic logic [1:0] plr_last_index(input logic [1:0] size);
    case (size)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [PLANE_W-1:0] plr_plane_pick(input logic [WORD_W-1:0] w,
                                                        input logic [1:0] sel);
    return w[sel*PLANE_W +: PLANE_W];
  endfunction

  // Per-bit colour match over the planes that are marked as taking part.
  function automatic logic [PLANE_W-1:0] plr_colour_match(input logic [WORD_W-1:0] w,
                                                          input logic [NPLANE-1:0] cmp,
                                                          input logic [NPLANE-1:0] dc);
    logic [PLANE_W-1:0] m;
    m = '1;
    for (int p = 0; p < NPLANE; p++) begin
      if (dc[p]) m = m & ~(w[p*PLANE_W +: PLANE_W] ^ {PLANE_W{cmp[p]}});
    end
    return m;
  endfunction
endpackage

// File: rtl/plr_seq.sv
module plr_seq
  import plr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              mem_rd_valid,
  output logic              req_ready,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic [1:0]        beat_idx,
  output logic              beat_take,
  output logic              rsp_valid
);
  plr_state_e        state_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        idx_q;
  logic [1:0]        last_q;
  logic              accept;

  assign req_ready   = (state_q == S_IDLE);
  assign accept      = req_valid && req_ready;
  assign mem_rd_en   = (state_q == S_ISSUE);
  assign mem_rd_addr = base_q + ADDR_W'(idx_q);
  assign beat_idx    = idx_q;
  assign beat_take   = (state_q == S_WAIT) && mem_rd_valid;
  assign rsp_valid   = (state_q == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      base_q  <= '0;
      idx_q   <= '0;
      last_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (accept) begin
          base_q  <= req_addr;
          idx_q   <= '0;
          last_q  <= plr_last_index(req_size);
          state_q <= S_ISSUE;
        end
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: if (mem_rd_valid) begin
          if (idx_q == last_q) state_q <= S_DONE;
          else begin
            idx_q   <= idx_q + 2'd1;
            state_q <= S_ISSUE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/plr_byte_sel.sv
module plr_byte_sel
  import plr_pkg::*;
(
  input  logic [WORD_W-1:0]  planes,
  input  plr_cfg_t           cfg,
  output logic [PLANE_W-1:0] result
);
  logic [PLANE_W-1:0] pick_byte;
  logic [PLANE_W-1:0] match_byte;

  assign pick_byte  = plr_plane_pick(planes, cfg.map);
  assign match_byte = plr_colour_match(planes, cfg.cmp, cfg.dc);
  assign result     = cfg.mode ? match_byte : pick_byte;
endmodule

// File: rtl/plr_store.sv
module plr_store
  import plr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               beat_take,
  input  logic [1:0]         beat_idx,
  input  logic [PLANE_W-1:0] beat_byte,
  input  logic [WORD_W-1:0]  mem_word,
  output logic [WORD_W-1:0]  latch_q,
  output logic [NLANE*PLANE_W-1:0] packed_q
);
  for (genvar p = 0; p < NPLANE; p++) begin : g_plane
    always_ff @(posedge clk) begin
      if (!rst_n)         latch_q[p*PLANE_W +: PLANE_W] <= '0;
      else if (beat_take) latch_q[p*PLANE_W +: PLANE_W] <= mem_word[p*PLANE_W +: PLANE_W];
    end
  end

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n || clear)
        packed_q[k*PLANE_W +: PLANE_W] <= '0;
      else if (beat_take && (beat_idx == 2'(k)))
        packed_q[k*PLANE_W +: PLANE_W] <= beat_byte;
    end
  end
endmodule

// File: rtl/plane_read_path.sv
module plane_read_path
  import plr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              rd_mode,
  input  logic [1:0]        map_sel,
  input  logic [3:0]        cmp_colour,
  input  logic [3:0]        dont_care,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [31:0]       mem_rd_data,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic [31:0]       latch_q
);
  plr_cfg_t           cfg_q;
  logic               accept;
  logic               beat_take;
  logic [1:0]         beat_idx;
  logic [PLANE_W-1:0] beat_byte;

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (accept) cfg_q <= '{mode: rd_mode, map: map_sel, cmp: cmp_colour, dc: dont_care};
  end

  plr_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
    .req_addr(req_addr), .mem_rd_valid(mem_rd_valid), .req_ready(req_ready),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .beat_idx(beat_idx),
    .beat_take(beat_take), .rsp_valid(rsp_valid)
  );

  plr_byte_sel u_sel (
    .planes(mem_rd_data), .cfg(cfg_q), .result(beat_byte)
  );

  plr_store u_store (
    .clk(clk), .rst_n(rst_n), .clear(accept), .beat_take(beat_take),
    .beat_idx(beat_idx), .beat_byte(beat_byte), .mem_word(mem_rd_data),
    .latch_q(latch_q), .packed_q(rsp_data)
  );
endmodule

// File: rtl/plr_checker.sv
module plr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_rd_en,
  input logic        beat_take,
  input logic [31:0] mem_rd_data,
  input logic        rsp_valid,
  input logic [31:0] latch_q
);
  // R7
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R7
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);
  // R7
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || rsp_valid) |-> !req_ready);
  // R2
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_take |=> (latch_q == $past(mem_rd_data)));
  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_take |=> $stable(latch_q));
endmodule

bind plane_read_path plr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_rd_en(mem_rd_en),
  .beat_take(beat_take), .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid),
  .latch_q(latch_q)
);

// File: tb/tb_plane_read_path.sv
module tb_plane_read_path;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        rd_mode = 1'b0;
  logic [1:0]  map_sel = '0;
  logic [3:0]  cmp_colour = '0;
  logic [3:0]  dont_care = '0;
  logic        mem_rd_en;
  logic [15:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [31:0] latch_q;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ret_cyc = 0;

  always #4 clk = ~clk;

  plane_read_path #(.ADDR_W(16)) dut (.*);

  function automatic logic [7:0] pv(input logic [15:0] a, input int p);
    logic [15:0] t;
    t = a * 16'd37 + 16'(p * 83 + 5);
    return t[7:0] ^ a[15:8];
  endfunction

  function automatic logic [31:0] pword(input logic [15:0] a);
    return {pv(a, 3), pv(a, 2), pv(a, 1), pv(a, 0)};
  endfunction

  function automatic logic [7:0] exp_byte(input logic [15:0] a, input logic m,
      input logic [1:0] ms, input logic [3:0] c, input logic [3:0] d);
    logic [7:0] r;
    if (!m) return pv(a, int'(ms));
    for (int i = 0; i < 8; i++) begin
      int bad = 0;
      for (int p = 0; p < 4; p++) begin
        logic [7:0] pb;
        pb = pv(a, p);
        if (d[p] && (pb[i] != c[p])) bad++;
      end
      r[i] = (bad == 0);
    end
    return r;
  endfunction

  // Plane memory model with random latency.
  logic        mbusy = 1'b0;
  logic [15:0] maddr = '0;
  int          mwait = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rd_valid <= 1'b0;
    if (mbusy) begin
      if (mwait == 0) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= pword(maddr);
        mbusy        <= 1'b0;
        ret_cyc      <= cyc;
      end else mwait <= mwait - 1;
    end
    if (mem_rd_en) begin
      mbusy <= 1'b1;
      maddr <= mem_rd_addr;
      mwait <= int'($urandom_range(0, 2));
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [15:0] a, input logic [1:0] sz, input logic m,
      input logic [1:0] ms, input logic [3:0] c, input logic [3:0] d,
      input bit perturb, input string tag);
    logic [31:0] exp;
    int n;
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    exp = '0;
    for (int k = 0; k < n; k++)
      exp[k*8 +: 8] = exp_byte(a + 16'(k), m, ms, c, d);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz;
    rd_mode = m; map_sel = ms; cmp_colour = c; dont_care = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (perturb) begin
      rd_mode = ~m; map_sel = ms + 2'd1; cmp_colour = ~c; dont_care = ~d;
      req_addr = a + 16'd9; req_size = 2'd0;
    end
    for (int w = 0; w < 200 && !rsp_valid; w++) @(negedge clk);
    chk(rsp_valid == 1'b1, {tag, " R7 response arrives"}, 32'(rsp_valid), 32'd1);
    chk(rsp_data == exp, {tag, " result"}, rsp_data, exp);
    chk(latch_q == pword(a + 16'(n - 1)), {tag, " R2 latch last address"},
        latch_q, pword(a + 16'(n - 1)));
    chk(cyc == ret_cyc + 2, {tag, " R7 one cycle after data"}, 32'(cyc), 32'(ret_cyc + 2));
    @(negedge clk);
    chk(!rsp_valid && req_ready, {tag, " R7 single pulse then idle"},
        {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready && !rsp_valid && !mem_rd_en && latch_q == 0, "R1 in reset",
        {latch_q[28:0], req_ready, rsp_valid, mem_rd_en}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_rd_en && latch_q == 0, "R1 after release",
        {latch_q[28:0], req_ready, rsp_valid, mem_rd_en}, 32'd4);

    // R3 each plane
    for (int s = 0; s < 4; s++)
      do_read(16'h0100 + 16'(s), 2'd0, 1'b0, 2'(s), 4'h0, 4'h0, 1'b0, "R3 plane select");
    // R4 full compare, R5 exclusions
    do_read(16'h0200, 2'd0, 1'b1, 2'd0, 4'hA, 4'hF, 1'b0, "R4 compare all planes");
    do_read(16'h0201, 2'd2, 1'b1, 2'd0, 4'h5, 4'h0, 1'b0, "R5 no planes gives FF");
    do_read(16'h0305, 2'd2, 1'b1, 2'd0, 4'h3, 4'h6, 1'b0, "R5 partial don't-care");
    do_read(16'h0407, 2'd0, 1'b1, 2'd0, 4'h0, 4'h1, 1'b0, "R4 single plane");
    // R6 sizes and wrap
    do_read(16'h0500, 2'd1, 1'b0, 2'd2, 4'h0, 4'h0, 1'b0, "R6 two bytes");
    do_read(16'h0600, 2'd3, 1'b0, 2'd1, 4'h0, 4'h0, 1'b0, "R6 size code 3");
    do_read(16'hFFFE, 2'd2, 1'b0, 2'd3, 4'h0, 4'h0, 1'b0, "R6 wrap at top");
    // R8 settings changed mid request
    do_read(16'hFFFD, 2'd2, 1'b1, 2'd0, 4'h9, 4'hD, 1'b1, "R8 compare held");
    do_read(16'h0777, 2'd2, 1'b0, 2'd2, 4'h0, 4'h0, 1'b1, "R8 plane held");

    for (int t = 0; t < 300; t++) begin
      logic [31:0] r;
      r = $urandom;
      do_read(16'($urandom), r[1:0], r[2], r[4:3], r[8:5], r[12:9], r[13],
              r[2] ? "R4 random compare" : "R3 random select");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule